// File: doc/BRIEF.md
# Converter Serial Readout Engine

This block is the device-side serial logic for a two-input, 10-bit converter. It runs on a fast system clock and oversamples the three host-driven serial pins: a serial clock, an active-low select and a data input. It drives a data output and an output-enable that a pad can use as its tri-state control. The host lowers the select and sends a start bit. Three configuration bits follow. The engine decodes them into an input-configuration code and opens a sample window. At the close of that window it latches the conversion word presented on a parallel input, which stands in for the converter core.

The word then leaves on the serial output. A low null bit comes first, then the word most significant bit first. If the host asks for it, the word is sent a second time least significant bit first. Zeros are sent after that for as long as the host keeps clocking. Raising the select ends a transfer at any point. After reset, the select must be seen high at least once before any transfer is accepted.

Top module: `adc_serial_engine`

## Requirements
- R1: If the select is low when reset ends, no start bit is accepted (output-enable, sample window and cfg_valid stay low) until the select has gone high and then low again.
- R2: While the select is low and no transfer is running, serial-clock rising edges with the data input low are ignored. The first rising edge with the data input high is the start bit.
- R3: The three rising edges after the start bit capture, in this order: a mode bit M, a selector bit S and an order bit O. chan_cfg_o = {M,S}, so 2'b10 selects input 0 single-ended, 2'b11 selects input 1 single-ended, 2'b00 makes input 0 positive and input 1 negative, and 2'b01 makes input 1 positive and input 0 negative. cfg_valid_o rises once S is captured, and chan_cfg_o holds steady while cfg_valid_o is high.
- R4: sample_win_o goes high on the second rising serial-clock edge after the start bit. It goes low on the falling edge that follows the order-bit rising edge. The conversion word is latched at that falling edge.
- R5: The output-enable and the data output are low while the select is high and before the null bit. On the falling edge after the order-bit rising edge, the output-enable goes high and a 0 null bit is driven.
- R6: The next DATA_W falling edges drive the latched word, most significant bit first.
- R7: With O=1, every later falling edge with the select low drives 0.
- R8: With O=0, the next DATA_W-1 falling edges drive bits 1 up to DATA_W-1 (bit 0 is not repeated), and 0 is driven after that indefinitely.
- R9: Raising the select aborts the transfer. The output-enable, the data output, cfg_valid_o and sample_win_o drop, and a new start bit is required.
- R10: The data output changes only after a falling serial-clock edge or when the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_sel_n_i | input | 1 | Active-low transfer select |
| ser_in_i | input | 1 | Serial data from host |
| conv_data_i | input | DATA_W | Conversion word from the converter core |
| ser_out_o | output | 1 | Serial data to host |
| ser_out_en_o | output | 1 | Drive enable for the serial output pad |
| chan_cfg_o | output | 2 | Input configuration code {M,S} |
| cfg_valid_o | output | 1 | chan_cfg_o is valid for this transfer |
| sample_win_o | output | 1 | Sample window open |

## Verification
The bench builds the engine with its defaults: DATA_W = 10 and two synchronizer stages. The serial clock runs with a half period of six system clocks, which leaves margin over the three-cycle edge latency. Frames of up to 34 serial clocks reach both output orders. They also go past the end of the least-significant-first repeat into the saturated range of the falling-edge counter, so the zero fill after it is exercised. All four configuration codes appear, together with leading zeros, a select held low through reset, a mid-word abort and a conversion word that changes both before and after the latch point.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  typedef enum logic [1:0] {
    FR_ARM  = 2'd0,
    FR_IDLE = 2'd1,
    FR_HUNT = 2'd2,
    FR_XFER = 2'd3
  } frame_st_e;

  localparam int PIN_CLK  = 0;
  localparam int PIN_SEL  = 1;
  localparam int PIN_DATA = 2;
  localparam int NUM_PINS = 3;
  localparam int NULL_IDX = 3;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] lvl_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/adc_frame_ctl.sv
module adc_frame_ctl
  import adc_serial_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_lvl,
  input  logic             sel_lvl,
  input  logic             data_lvl,
  output logic             in_xfer,
  output logic             xfer_st,
  output logic             step,
  output logic [CNT_W-1:0] step_idx,
  output logic             lsb_rep,
  output logic [1:0]       chan_cfg,
  output logic             cfg_valid,
  output logic             sample_win
);
  frame_st_e        st_q, st_n;
  logic             prev_q;
  logic [1:0]       rcnt_q, rcnt_n;
  logic [CNT_W-1:0] fcnt_q, fcnt_n;
  logic             mode_q, mode_n, selb_q, selb_n, ord_q, ord_n;
  logic             vld_q, vld_n, win_q, win_n;
  logic             rise, fall;

  assign rise = clk_lvl & ~prev_q;
  assign fall = ~clk_lvl & prev_q;

  always_comb begin
    st_n   = st_q;
    rcnt_n = rcnt_q;
    fcnt_n = fcnt_q;
    mode_n = mode_q;
    selb_n = selb_q;
    ord_n  = ord_q;
    vld_n  = vld_q;
    win_n  = win_q;
    case (st_q)
      FR_ARM:  if (sel_lvl) st_n = FR_IDLE;
      FR_IDLE: if (!sel_lvl) st_n = FR_HUNT;
      FR_HUNT: begin
        if (sel_lvl) st_n = FR_IDLE;
        else if (rise && data_lvl) begin
          st_n   = FR_XFER;
          rcnt_n = '0;
          fcnt_n = '0;
          vld_n  = 1'b0;
          win_n  = 1'b0;
        end
      end
      default: begin
        if (sel_lvl) begin
          st_n  = FR_IDLE;
          vld_n = 1'b0;
          win_n = 1'b0;
        end else begin
          if (rise) begin
            case (rcnt_q)
              2'd0: mode_n = data_lvl;
              2'd1: begin
                selb_n = data_lvl;
                vld_n  = 1'b1;
                win_n  = 1'b1;
              end
              2'd2: ord_n = data_lvl;
              default: ;
            endcase
            if (rcnt_q != 2'd3) rcnt_n = rcnt_q + 2'd1;
          end
          if (fall) begin
            if (fcnt_q == CNT_W'(NULL_IDX)) win_n = 1'b0;
            if (fcnt_q != '1) fcnt_n = fcnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_ARM;
      prev_q <= 1'b0;
      rcnt_q <= '0;
      fcnt_q <= '0;
      mode_q <= 1'b0;
      selb_q <= 1'b0;
      ord_q  <= 1'b0;
      vld_q  <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      prev_q <= clk_lvl;
      rcnt_q <= rcnt_n;
      fcnt_q <= fcnt_n;
      mode_q <= mode_n;
      selb_q <= selb_n;
      ord_q  <= ord_n;
      vld_q  <= vld_n;
      win_q  <= win_n;
    end
  end

  assign xfer_st    = (st_q == FR_XFER);
  assign in_xfer    = xfer_st & ~sel_lvl;
  assign step       = in_xfer & fall;
  assign step_idx   = fcnt_q;
  assign lsb_rep    = ~ord_q;
  assign chan_cfg   = {mode_q, selb_q};
  assign cfg_valid  = vld_q;
  assign sample_win = win_q;
endmodule

// File: rtl/adc_out_shift.sv
module adc_out_shift
  import adc_serial_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_xfer,
  input  logic              step,
  input  logic [CNT_W-1:0]  step_idx,
  input  logic              lsb_rep,
  input  logic [DATA_W-1:0] conv_data,
  output logic              out_bit,
  output logic              out_en
);
  logic [DATA_W-1:0] word_q, word_n;
  logic              bit_q, bit_n, en_q, en_n, word_en;

  always_comb begin
    bit_n   = bit_q;
    en_n    = en_q;
    word_n  = word_q;
    word_en = 1'b0;
    if (!in_xfer) begin
      bit_n = 1'b0;
      en_n  = 1'b0;
    end else if (step) begin
      bit_n = 1'b0;
      if (step_idx == CNT_W'(NULL_IDX)) begin
        en_n    = 1'b1;
        word_n  = conv_data;
        word_en = 1'b1;
      end
      for (int b = 0; b < DATA_W; b++) begin
        if (step_idx == CNT_W'(NULL_IDX + DATA_W - b)) bit_n = word_q[b];
      end
      for (int b = 1; b < DATA_W; b++) begin
        if (lsb_rep && step_idx == CNT_W'(NULL_IDX + DATA_W + b)) bit_n = word_q[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (word_en) word_q <= word_n;
      bit_q <= bit_n;
      en_q  <= en_n;
    end
  end

  assign out_bit = bit_q;
  assign out_en  = en_q;
endmodule

// File: rtl/adc_serial_engine.sv
module adc_serial_engine
  import adc_serial_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_sel_n_i,
  input  logic              ser_in_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              ser_out_o,
  output logic              ser_out_en_o,
  output logic [1:0]        chan_cfg_o,
  output logic              cfg_valid_o,
  output logic              sample_win_o
);
  localparam int CNT_W = $clog2(2 * DATA_W + NULL_IDX + 2);

  logic [1:0]          rst_pipe_q;
  logic                arst_sync_n;
  logic [NUM_PINS-1:0] pins, lvl;
  logic                in_xfer, xfer_st, step, lsb_rep;
  logic [CNT_W-1:0]    step_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_sync_n = rst_pipe_q[1];

  always_comb begin
    pins           = '0;
    pins[PIN_CLK]  = ser_clk_i;
    pins[PIN_SEL]  = ser_sel_n_i;
    pins[PIN_DATA] = ser_in_i;
  end

  adc_pin_sync #(.N_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(arst_sync_n), .pin_i(pins), .lvl_o(lvl)
  );

  adc_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(arst_sync_n),
    .clk_lvl(lvl[PIN_CLK]), .sel_lvl(lvl[PIN_SEL]), .data_lvl(lvl[PIN_DATA]),
    .in_xfer(in_xfer), .xfer_st(xfer_st), .step(step), .step_idx(step_idx),
    .lsb_rep(lsb_rep), .chan_cfg(chan_cfg_o), .cfg_valid(cfg_valid_o),
    .sample_win(sample_win_o)
  );

  adc_out_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(arst_sync_n), .in_xfer(in_xfer), .step(step),
    .step_idx(step_idx), .lsb_rep(lsb_rep), .conv_data(conv_data_i),
    .out_bit(ser_out_o), .out_en(ser_out_en_o)
  );
endmodule

// File: rtl/adc_serial_engine_chk.sv
module adc_serial_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_out_o,
  input logic       ser_out_en_o,
  input logic       sample_win_o,
  input logic       cfg_valid_o,
  input logic [1:0] chan_cfg_o,
  input logic       step,
  input logic       in_xfer,
  input logic       xfer_st,
  input logic       sel_lvl
);
  // R10
  out_chg_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out_o != $past(ser_out_o)) |-> ($past(step) || !$past(in_xfer)));

  // R5
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_out_en_o |-> !ser_out_o);

  // R5
  en_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_out_en_o) |-> $past(step));

  // R4
  win_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_win_o |-> xfer_st);

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_o && $past(cfg_valid_o)) |-> $stable(chan_cfg_o));

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_st && sel_lvl) |=> (!ser_out_en_o && !cfg_valid_o && !sample_win_o));
endmodule

bind adc_serial_engine adc_serial_engine_chk u_chk (
  .clk(clk), .rst_n(arst_sync_n), .ser_out_o(ser_out_o),
  .ser_out_en_o(ser_out_en_o), .sample_win_o(sample_win_o),
  .cfg_valid_o(cfg_valid_o), .chan_cfg_o(chan_cfg_o), .step(step),
  .in_xfer(in_xfer), .xfer_st(xfer_st), .sel_lvl(lvl[1])
);

// File: tb/adc_serial_engine_bench.sv
module adc_serial_engine_bench;
  localparam int DW = 10;
  localparam int H  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0, sel_n = 1'b1, sdi = 1'b0;
  logic [DW-1:0] conv = '0;
  logic          sdo, sdo_en, cvld, win;
  logic [1:0]    ccfg;
  int            total = 0, bad = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_engine #(.DATA_W(DW), .SYNC_STAGES(2)) u_adc_serial_engine (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_sel_n_i(sel_n),
    .ser_in_i(sdi), .conv_data_i(conv), .ser_out_o(sdo),
    .ser_out_en_o(sdo_en), .chan_cfg_o(ccfg), .cfg_valid_o(cvld),
    .sample_win_o(win)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock with a given data bit; samples taken late in the high phase
  task automatic pulse(input logic d, output logic o_mid, output logic o_end,
                       output logic e_end, output logic w_end);
    sdi = d;
    wclk(H);
    sck = 1'b1;
    wclk(H / 2);
    o_mid = sdo;
    wclk(H - H / 2);
    o_end = sdo; e_end = sdo_en; w_end = win;
    sck = 1'b0;
  endtask

  task automatic t_reset_sel_low();
    logic a, b, c, d;
    sel_n = 1'b0;
    rst_n = 1'b0;
    wclk(4);
    rst_n = 1'b1;
    wclk(8);
    chk(sdo_en == 1'b0, "R5 en after reset", sdo_en, 0);
    chk(sdo == 1'b0, "R5 out after reset", sdo, 0);
    for (int j = 0; j < 6; j++) begin
      pulse(1'b1, a, b, c, d);
      chk(c == 1'b0 && d == 1'b0 && cvld == 1'b0, "R1 no frame with select low from reset",
          {c, d, cvld}, 0);
    end
    sel_n = 1'b1;
    wclk(8);
  endtask

  task automatic t_frame(input int lead, input logic m, input logic s, input logic o,
                         input logic [DW-1:0] word, input int npulse);
    logic a, b, c, d, exp;
    sel_n = 1'b1;
    wclk(8);
    conv = ~word;
    sel_n = 1'b0;
    wclk(8);
    for (int j = 0; j < lead; j++) begin
      pulse(1'b0, a, b, c, d);
      chk(c == 1'b0 && cvld == 1'b0, "R2 leading zero ignored", {c, cvld}, 0);
    end
    for (int j = 0; j < npulse; j++) begin
      logic din;
      din = (j == 0) ? 1'b1 : (j == 1) ? m : (j == 2) ? s : (j == 3) ? o : 1'b1;
      pulse(din, a, b, c, d);
      if (j == 1) conv = word;
      if (j == 5) conv = ~word;
      if (j <= 3) exp = 1'b0;
      else if (j == 4) exp = 1'b0;
      else if (j <= 4 + DW) exp = word[4 + DW - j];
      else if (!o && j <= 3 + 2 * DW) exp = word[j - 4 - DW];
      else exp = 1'b0;
      chk(a == b, "R10 stable while clock high", b, a);
      if (j <= 3) chk(c == 1'b0 && b == 1'b0, "R5 quiet before null bit", {c, b}, 0);
      else if (j == 4) chk(c == 1'b1 && b == 1'b0, "R5 null bit", {c, b}, 2);
      else if (j <= 4 + DW) chk(b == exp, "R6 msb-first bit", b, exp);
      else if (o) chk(b == 1'b0, "R7 zero fill", b, 0);
      else chk(b == exp, "R8 lsb-first repeat and zero fill", b, exp);
      if (j <= 4) chk(d == (j == 2 || j == 3), "R4 sample window", d, (j == 2 || j == 3));
      if (j == 3) begin
        chk(cvld == 1'b1, "R3 cfg valid", cvld, 1);
        chk(ccfg == {m, s}, "R3 cfg code", ccfg, {m, s});
      end
    end
    sel_n = 1'b1;
    wclk(6);
    chk(sdo_en == 1'b0 && sdo == 1'b0, "R5 quiet with select high", {sdo_en, sdo}, 0);
  endtask

  task automatic t_abort();
    logic a, b, c, d;
    sel_n = 1'b1;
    wclk(8);
    conv = 10'h3FF;
    sel_n = 1'b0;
    wclk(8);
    pulse(1'b1, a, b, c, d);
    pulse(1'b1, a, b, c, d);
    pulse(1'b1, a, b, c, d);
    pulse(1'b1, a, b, c, d);
    for (int j = 0; j < 5; j++) pulse(1'b0, a, b, c, d);
    chk(b == 1'b1 && c == 1'b1, "R9 frame running before abort", {c, b}, 3);
    sel_n = 1'b1;
    wclk(6);
    chk(sdo_en == 1'b0 && sdo == 1'b0 && cvld == 1'b0 && win == 1'b0,
        "R9 outputs drop on abort", {sdo_en, sdo, cvld, win}, 0);
    sel_n = 1'b0;
    wclk(8);
    for (int j = 0; j < 6; j++) begin
      pulse(1'b0, a, b, c, d);
      chk(c == 1'b0 && cvld == 1'b0, "R9 no resume without start bit", {c, cvld}, 0);
    end
    sel_n = 1'b1;
    wclk(8);
  endtask

  initial begin
    t_reset_sel_low();
    t_frame(0, 1'b1, 1'b0, 1'b1, 10'h2A5, 20);
    t_frame(5, 1'b1, 1'b1, 1'b0, 10'h3C1, 34);
    t_frame(3, 1'b0, 1'b0, 1'b0, 10'h001, 26);
    t_abort();
    t_frame(0, 1'b0, 1'b1, 1'b1, 10'h3FE, 16);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule